// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the word-select (frame-sync) level for a serial audio port. It advances only on cycles where the chosen bit-clock tick is high. It divides each frame into a high phase and a low phase. The length of each phase comes from its own register, and each register holds the phase length minus one. For a frame of R bit clocks, software writes floor(R/2) − 1 to the high register and ceil(R/2) − 1 to the low register. Odd frame lengths therefore still come out close to an even duty cycle. The frame length is normally slot width times slot count, unless an explicit ratio overrides it.

Alongside the level, the block gives a one-cycle strobe at each frame start and a running bit index for downstream serializers. Up to `NSRC` tick sources arrive in parallel, and a select field picks one of them. Period writes are held back until the next frame boundary, so a phase that is under way is never cut short or stretched.

Top module: `fsync_gen`

## Requirements
- R1: After reset, `fsync_o`, `frame_start_o` and `bit_idx_o` are 0. All four registers are 0, so the generator is disabled and no source is selected.
- R2: While the enable bit is clear, all three outputs stay at 0 whatever the tick inputs do.
- R3: On the first selected tick after enable is set, the outputs show `fsync_o`=1, `frame_start_o`=1 and `bit_idx_o`=0 in the cycle after that tick.
- R4: With high register H and low register L, `fsync_o` is 1 for H+1 selected ticks and then 0 for L+1 selected ticks, so a frame is H+L+2 ticks. For odd R, H=floor(R/2)−1 and L=ceil(R/2)−1 give a frame of R ticks.
- R5: `frame_start_o` is high for exactly one clock cycle, and only in the cycle after a tick that begins a frame.
- R6: `bit_idx_o` is 0 at each frame start and rises by one on every later selected tick of the frame. On cycles without a selected tick, `bit_idx_o` and `fsync_o` hold their values.
- R7: A select value of 0 picks no source. A value k from 1 to NSRC picks `bclk_tick_i[k-1]`. A value above NSRC picks no source. Ticks on unselected inputs have no effect.
- R8: A write to the high or low register while a frame is running does not change that frame. The new values take effect from the next frame start.
- R9: Clearing the enable bit returns all outputs to 0 one cycle after the register changes. Setting it again restarts the frame as in R3.
- R10: Register map by `wr_addr_i`: address 0 holds enable in data bit 0; address 1 holds select in data bits 3:0; address 2 holds the high value; address 3 holds the low value. A register changes only on a cycle with `wr_en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_tick_i | input | NSRC | One bit-clock tick per candidate source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | PW | Register write data |
| fsync_o | output | 1 | Frame-sync level |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |
| bit_idx_o | output | PW+1 | Bit position within the current frame |

## Verification
A register write that is presented at one clock edge changes the register at that edge. The counter core first sees the new value in the following cycle. A selected tick that is sampled at an edge changes the outputs right after that same edge, so each output follows its tick by one cycle. The bench applies every write and every tick at a falling edge and reads the outputs at the next falling edge. That read falls exactly one rising edge after the stimulus. Its reference model updates the expected enable, select and period values only after the write cycle has completed, and it latches the per-frame high and low values at the frame start, the same point at which the design latches them.

// File: rtl/fsync_gen_pkg.sv
package fsync_gen_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_SEL  = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_LO   = 2'd3
  } fsg_addr_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } fsg_phase_e;

endpackage

// File: rtl/fsync_gen_regs.sv
module fsync_gen_regs #(
  parameter int PW    = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [PW-1:0]    wr_data_i,
  output logic             enable_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [PW-1:0]    hi_o,
  output logic [PW-1:0]    lo_o
);
  import fsync_gen_pkg::*;

  fsg_addr_e addr;
  assign addr = fsg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      enable_o <= 1'b0;
      sel_o    <= '0;
      hi_o     <= '0;
      lo_o     <= '0;
    end else if (wr_en_i) begin
      unique case (addr)
        ADDR_CTRL: enable_o <= wr_data_i[0];
        ADDR_SEL:  sel_o    <= wr_data_i[SEL_W-1:0];
        ADDR_HI:   hi_o     <= wr_data_i;
        ADDR_LO:   lo_o     <= wr_data_i;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/fsync_gen_tick_mux.sv
module fsync_gen_tick_mux #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 4
) (
  input  logic [NSRC-1:0]  tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [NSRC-1:0] hit;

  // Select value k picks source k-1; 0 and out-of-range values pick none.
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign hit[k] = (sel_i == SEL_W'(k + 1)) && tick_i[k];
  end

  assign tick_o = |hit;

endmodule

// File: rtl/fsync_gen_core.sv
module fsync_gen_core #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          enable_i,
  input  logic          tick_i,
  input  logic [PW-1:0] hi_i,
  input  logic [PW-1:0] lo_i,
  output logic          fsync_o,
  output logic          frame_start_o,
  output logic [PW:0]   bit_idx_o,
  output logic [PW-1:0] frame_hi_o,
  output logic [PW-1:0] frame_lo_o
);
  import fsync_gen_pkg::*;

  fsg_phase_e    phase;
  logic          running;
  logic [PW-1:0] phase_cnt;
  logic          hi_done;
  logic          frame_done;
  logic          begin_frame;

  assign hi_done     = (phase == PH_HIGH) && (phase_cnt == frame_hi_o);
  assign frame_done  = (phase == PH_LOW)  && (phase_cnt == frame_lo_o);
  assign begin_frame = !running || frame_done;

  always_ff @(posedge clk_i) begin
    if (rst_i || !enable_i) begin
      running       <= 1'b0;
      phase         <= PH_HIGH;
      phase_cnt     <= '0;
      fsync_o       <= 1'b0;
      frame_start_o <= 1'b0;
      bit_idx_o     <= '0;
      if (rst_i) begin
        frame_hi_o <= '0;
        frame_lo_o <= '0;
      end
    end else begin
      frame_start_o <= 1'b0;
      if (tick_i) begin
        if (begin_frame) begin
          // Period values are sampled only here, at a frame boundary.
          running       <= 1'b1;
          phase         <= PH_HIGH;
          phase_cnt     <= '0;
          fsync_o       <= 1'b1;
          frame_start_o <= 1'b1;
          bit_idx_o     <= '0;
          frame_hi_o    <= hi_i;
          frame_lo_o    <= lo_i;
        end else if (hi_done) begin
          phase     <= PH_LOW;
          phase_cnt <= '0;
          fsync_o   <= 1'b0;
          bit_idx_o <= bit_idx_o + 1'b1;
        end else begin
          phase_cnt <= phase_cnt + 1'b1;
          bit_idx_o <= bit_idx_o + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int NSRC  = 4,
  parameter int PW    = 8,
  parameter int SEL_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NSRC-1:0] bclk_tick_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [PW-1:0]   wr_data_i,
  output logic            fsync_o,
  output logic            frame_start_o,
  output logic [PW:0]     bit_idx_o
);

  logic             en_w;
  logic [SEL_W-1:0] sel_w;
  logic [PW-1:0]    hi_w;
  logic [PW-1:0]    lo_w;
  logic             tick_w;
  logic [PW-1:0]    frame_hi_w;
  logic [PW-1:0]    frame_lo_w;

  fsync_gen_regs #(.PW(PW), .SEL_W(SEL_W)) u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .enable_o (en_w),
    .sel_o    (sel_w),
    .hi_o     (hi_w),
    .lo_o     (lo_w)
  );

  fsync_gen_tick_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .tick_i(bclk_tick_i),
    .sel_i (sel_w),
    .tick_o(tick_w)
  );

  fsync_gen_core #(.PW(PW)) u_core (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .enable_i     (en_w),
    .tick_i       (tick_w),
    .hi_i         (hi_w),
    .lo_i         (lo_w),
    .fsync_o      (fsync_o),
    .frame_start_o(frame_start_o),
    .bit_idx_o    (bit_idx_o),
    .frame_hi_o   (frame_hi_w),
    .frame_lo_o   (frame_lo_w)
  );

endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk #(
  parameter int PW = 8
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          en_i,
  input logic          tick_i,
  input logic          fsync_i,
  input logic          fstart_i,
  input logic [PW:0]   idx_i,
  input logic [PW-1:0] fhi_i,
  input logic [PW-1:0] flo_i
);

  logic armed = 1'b0;
  always_ff @(posedge clk_i) armed <= !rst_i;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !en_i |=> (!fsync_i && !fstart_i && idx_i == '0)) else $error("idle"); // R2

  AST_RISE_IS_START: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    $rose(fsync_i) |-> fstart_i) else $error("rise"); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    fstart_i |=> !fstart_i) else $error("pulse"); // R5

  AST_START_IDX_ZERO: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    fstart_i |-> (fsync_i && idx_i == '0)) else $error("idx0"); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (en_i && !tick_i) |=> ($stable(fsync_i) && $stable(idx_i))) else $error("hold"); // R6

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    idx_i <= ({1'b0, fhi_i} + {1'b0, flo_i} + 1'b1)) else $error("bound"); // R4

endmodule

bind fsync_gen fsync_gen_chk #(.PW(PW)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .en_i    (en_w),
  .tick_i  (tick_w),
  .fsync_i (fsync_o),
  .fstart_i(frame_start_o),
  .idx_i   (bit_idx_o),
  .fhi_i   (frame_hi_w),
  .flo_i   (frame_lo_w)
);

// File: tb/fsync_gen_tb.sv
module fsync_gen_tb;
  localparam int NSRC = 4;
  localparam int PW   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] bclk = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [PW-1:0]   wr_data = '0;
  logic            fsync, fstart;
  logic [PW:0]     idx;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int prog_en = 0, prog_sel = 0, prog_hi = 0, prog_lo = 0;
  int m_run = 0, m_p = 0, m_fhi = 0, m_flo = 0, m_start = 0;

  always #10 clk = ~clk;

  fsync_gen #(.NSRC(NSRC), .PW(PW)) u_dut (
    .clk_i(clk), .rst_i(rst), .bclk_tick_i(bclk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .fsync_o(fsync),
    .frame_start_o(fstart), .bit_idx_o(idx)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = PW'(d);
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: begin prog_en = d & 1; if (prog_en == 0) m_run = 0; end
      1: prog_sel = d & 15;
      2: prog_hi = d & 255;
      default: prog_lo = d & 255;
    endcase
  endtask

  task automatic tick(input logic [NSRC-1:0] m, input string req);
    bit sel_hit;
    int e_fs, e_idx;
    bclk = m;
    @(negedge clk);
    bclk = '0;
    sel_hit = (prog_sel >= 1 && prog_sel <= NSRC) ? m[prog_sel-1] : 1'b0;
    m_start = 0;
    if (prog_en == 0) m_run = 0;
    else if (sel_hit) begin
      if (m_run == 0) begin
        m_run = 1; m_p = 0; m_fhi = prog_hi; m_flo = prog_lo; m_start = 1;
      end else begin
        m_p++;
        if (m_p == m_fhi + m_flo + 2) begin
          m_p = 0; m_fhi = prog_hi; m_flo = prog_lo; m_start = 1;
        end
      end
    end
    e_fs  = (m_run != 0 && m_p <= m_fhi) ? 1 : 0;
    e_idx = (m_run != 0) ? m_p : 0;
    chk(req, "fsync", int'(fsync), e_fs);
    chk(req, "frame_start", int'(fstart), m_start);
    chk(req, "bit_idx", int'(idx), e_idx);
  endtask

  task automatic run_ticks(input int n, input int src, input string req);
    for (int i = 0; i < n; i++) begin
      tick(NSRC'(1 << src), req);
      if (i % 3 == 1) tick('0, "R6");
    end
  endtask

  task automatic t_reset();
    chk("R1", "fsync", int'(fsync), 0);
    chk("R1", "frame_start", int'(fstart), 0);
    chk("R1", "bit_idx", int'(idx), 0);
    tick('1, "R1");
  endtask

  task automatic t_disabled();
    wr(1, 1);
    for (int i = 0; i < 4; i++) tick('1, "R2");
  endtask

  task automatic t_basic();
    wr(2, 3); wr(3, 3); wr(1, 1); wr(0, 1);
    run_ticks(20, 0, "R4");
    wr(0, 0);
  endtask

  task automatic t_odd();
    wr(2, 2); wr(3, 3); wr(1, 2); wr(0, 1);
    run_ticks(16, 1, "R4");
    wr(0, 0);
  endtask

  task automatic t_min();
    wr(2, 0); wr(3, 0); wr(1, 4); wr(0, 1);
    run_ticks(7, 3, "R3");
    wr(0, 0);
  endtask

  task automatic t_select();
    wr(2, 1); wr(3, 1);
    wr(1, 0); wr(0, 1);
    tick('1, "R7");
    wr(1, 5);
    tick('1, "R7");
    wr(1, 3);
    tick(4'b1011, "R7");
    tick(4'b0100, "R7");
    tick(4'b1011, "R7");
    tick(4'b0100, "R7");
    wr(0, 0);
  endtask

  task automatic t_midframe();
    wr(1, 1); wr(2, 2); wr(3, 2); wr(0, 1);
    run_ticks(2, 0, "R8");
    wr(2, 5); wr(3, 1);
    run_ticks(4, 0, "R8");
    run_ticks(8, 0, "R8");
    wr(0, 0);
  endtask

  task automatic t_restart();
    wr(1, 1); wr(2, 4); wr(3, 4); wr(0, 1);
    run_ticks(3, 0, "R9");
    wr(0, 0);
    tick('0, "R9");
    tick('1, "R9");
    wr(0, 1);
    run_ticks(4, 0, "R9");
    wr(0, 0);
  endtask

  task automatic t_ignored_write();
    wr(1, 1);
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = PW'(1);
    @(negedge clk);
    tick('1, "R10");
    wr_en = 1'b0; wr_addr = 2'd1; wr_data = PW'(0);
    @(negedge clk);
    wr(0, 1);
    tick(4'b0001, "R10");
    wr(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_odd();
    t_min();
    t_select();
    t_midframe();
    t_restart();
    t_ignored_write();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule